// File: doc/BRIEF.md
# Capability Seal and Unseal Unit

This block turns capability register values into opaque sealed tokens and back again, and performs guarded edits on them. A capability is carried as a validity tag, an address, a permission vector, a base and top bound, and a small object-type field. An object type of zero marks an unsealed capability; any other value marks a sealed one. Sealing stamps the source with a type taken from the address of an authority capability, and unsealing clears the type again only when a suitably privileged authority presents the same address.

No operation ever traps. A refused seal, a refused unseal, or an attempt to edit a sealed value all return the input fields with the tag cleared, so software can detect tampering by inspecting the tag. Each request is presented with a strobe and an opcode, and the result appears on registered outputs one cycle later. The result also carries a flag saying whether it is a sealed executable capability, which a jump unit can use to recognise sealed entry points.

Top module: `cap_seal_unit`

## Requirements
- R1: While reset is asserted, and after release until the first request, `o_valid` and `o_tag` are 0.
- R2: Opcode 01 seals. Permission bits are: 0 global, 1 load, 2 store, 3 execute, 4 seal, 5 unseal, 6 user. The seal is granted when the authority tag is 1, `auth_seal_perm` is 1, the source object type is 0, and the authority address lies in 1 to 2^OTYPE_W-1; then the result equals the source with the object type set to the low bits of the authority address and the tag kept.
- R3: A seal that is not granted returns the source fields unchanged with the tag cleared.
- R4: Opcode 00 modifies: an enabled address change replaces the address, an enabled bounds change replaces base and top, an enabled permission change ANDs the permissions with the mask. If the source object type is non-zero and any change is enabled, the result tag is 0; otherwise the tag is kept.
- R5: Opcode 10 unseals. It is granted when the authority tag is 1, `auth_unseal_perm` is 1, the source object type is non-zero, and the authority address equals the object type zero-extended; the result equals the source with object type 0 and the tag kept.
- R6: An unseal that is not granted (mismatched address, missing permission, untagged authority, or unsealed source) returns the source fields unchanged with the tag cleared.
- R7: Opcode 11, and opcode 00 with no change enabled, copy the source unchanged, including a sealed object type and its tag.
- R8: `o_exec_sealed` is 1 exactly when the result object type is non-zero and result permission bit 3 is set.
- R9: The result and `o_valid` appear one clock after a request with `i_valid` high; with `i_valid` low, `o_valid` is 0 next cycle and the result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Request strobe |
| i_op | input | 2 | 00 modify, 01 seal, 10 unseal, 11 pass |
| src_tag | input | 1 | Source validity tag |
| src_addr | input | ADDR_W | Source address |
| src_perm | input | PERM_W | Source permissions |
| src_base | input | ADDR_W | Source lower bound |
| src_top | input | ADDR_W | Source upper bound |
| src_otype | input | OTYPE_W | Source object type |
| auth_tag | input | 1 | Authority validity tag |
| auth_addr | input | ADDR_W | Authority address |
| auth_seal_perm | input | 1 | Authority holds the seal permission |
| auth_unseal_perm | input | 1 | Authority holds the unseal permission |
| mod_addr_en | input | 1 | Modify: replace address |
| mod_addr | input | ADDR_W | Modify: new address |
| mod_bnd_en | input | 1 | Modify: replace bounds |
| mod_base | input | ADDR_W | Modify: new base |
| mod_top | input | ADDR_W | Modify: new top |
| mod_perm_en | input | 1 | Modify: restrict permissions |
| mod_perm_mask | input | PERM_W | Modify: permission AND mask |
| o_valid | output | 1 | Result strobe |
| o_tag | output | 1 | Result tag |
| o_addr | output | ADDR_W | Result address |
| o_perm | output | PERM_W | Result permissions |
| o_base | output | ADDR_W | Result base |
| o_top | output | ADDR_W | Result top |
| o_otype | output | OTYPE_W | Result object type |
| o_exec_sealed | output | 1 | Result is a sealed executable capability |

## Verification
Seals are tried with each grant condition broken on its own (untagged authority, missing permission, authority address of zero and one past the type range, already sealed source), which separates the individual terms of the grant from one another. Unseals are tried with a matching address, a neighbouring address, a missing permission and an unsealed source, telling an exact address match apart from a partial one. Edits are applied to sealed and unsealed sources with each enable alone and with none, which separates tag clearing on a touched sealed value from a plain copy. A long run of random requests with authority addresses clustered around the type range, interleaved with idle cycles, is compared each clock against a behavioural model to catch interactions and the hold behaviour.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    OP_MODIFY = 2'b00,
    OP_SEAL   = 2'b01,
    OP_UNSEAL = 2'b10,
    OP_PASS   = 2'b11
  } cap_op_e;

  localparam int PERM_GLOBAL = 0;
  localparam int PERM_LOAD   = 1;
  localparam int PERM_STORE  = 2;
  localparam int PERM_EXEC   = 3;
  localparam int PERM_SEAL   = 4;
  localparam int PERM_UNSEAL = 5;
  localparam int PERM_USER   = 6;
endpackage

// File: rtl/cap_type_gate.sv
// Decides whether a seal or unseal is granted and computes the resulting
// tag and object type. All other fields pass through untouched.
module cap_type_gate #(
  parameter int ADDR_W  = 32,
  parameter int OTYPE_W = 3
) (
  input  logic               do_unseal,
  input  logic               src_tag,
  input  logic [OTYPE_W-1:0] src_otype,
  input  logic               auth_tag,
  input  logic [ADDR_W-1:0]  auth_addr,
  input  logic               auth_seal_perm,
  input  logic               auth_unseal_perm,
  output logic               res_tag,
  output logic [OTYPE_W-1:0] res_otype
);
  logic src_sealed;
  logic addr_fits;
  logic addr_match;
  logic seal_grant;
  logic unseal_grant;
  logic grant;

  always_comb begin
    src_sealed   = (src_otype != '0);
    addr_fits    = (auth_addr != '0) && ((auth_addr >> OTYPE_W) == '0);
    addr_match   = (auth_addr == ADDR_W'(src_otype));
    seal_grant   = auth_tag && auth_seal_perm && !src_sealed && addr_fits;
    unseal_grant = auth_tag && auth_unseal_perm && src_sealed && addr_match;
    grant        = do_unseal ? unseal_grant : seal_grant;
    res_tag      = src_tag && grant;
    if (!grant)
      res_otype = src_otype;
    else if (do_unseal)
      res_otype = '0;
    else
      res_otype = auth_addr[OTYPE_W-1:0];
  end
endmodule

// File: rtl/cap_field_edit.sv
// Applies address, bounds and permission edits; a touched sealed value
// loses its tag.
module cap_field_edit #(
  parameter int ADDR_W  = 32,
  parameter int PERM_W  = 7,
  parameter int OTYPE_W = 3
) (
  input  logic               src_tag,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [PERM_W-1:0]  src_perm,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [ADDR_W-1:0]  src_top,
  input  logic [OTYPE_W-1:0] src_otype,
  input  logic               addr_en,
  input  logic [ADDR_W-1:0]  new_addr,
  input  logic               bnd_en,
  input  logic [ADDR_W-1:0]  new_base,
  input  logic [ADDR_W-1:0]  new_top,
  input  logic               perm_en,
  input  logic [PERM_W-1:0]  perm_mask,
  output logic               res_tag,
  output logic [ADDR_W-1:0]  res_addr,
  output logic [PERM_W-1:0]  res_perm,
  output logic [ADDR_W-1:0]  res_base,
  output logic [ADDR_W-1:0]  res_top
);
  logic touched;

  always_comb begin
    touched  = addr_en || bnd_en || perm_en;
    res_tag  = src_tag && !(touched && (src_otype != '0));
    res_addr = addr_en ? new_addr : src_addr;
    res_base = bnd_en  ? new_base : src_base;
    res_top  = bnd_en  ? new_top  : src_top;
    res_perm = perm_en ? (src_perm & perm_mask) : src_perm;
  end
endmodule

// File: rtl/cap_seal_unit.sv
module cap_seal_unit
  import cap_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PERM_W  = 7,
  parameter int OTYPE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_valid,
  input  logic [1:0]         i_op,
  input  logic               src_tag,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [PERM_W-1:0]  src_perm,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [ADDR_W-1:0]  src_top,
  input  logic [OTYPE_W-1:0] src_otype,
  input  logic               auth_tag,
  input  logic [ADDR_W-1:0]  auth_addr,
  input  logic               auth_seal_perm,
  input  logic               auth_unseal_perm,
  input  logic               mod_addr_en,
  input  logic [ADDR_W-1:0]  mod_addr,
  input  logic               mod_bnd_en,
  input  logic [ADDR_W-1:0]  mod_base,
  input  logic [ADDR_W-1:0]  mod_top,
  input  logic               mod_perm_en,
  input  logic [PERM_W-1:0]  mod_perm_mask,
  output logic               o_valid,
  output logic               o_tag,
  output logic [ADDR_W-1:0]  o_addr,
  output logic [PERM_W-1:0]  o_perm,
  output logic [ADDR_W-1:0]  o_base,
  output logic [ADDR_W-1:0]  o_top,
  output logic [OTYPE_W-1:0] o_otype,
  output logic               o_exec_sealed
);
  localparam int EXEC_BIT = PERM_EXEC;

  // Sealing and unsealing path
  logic               gate_tag;
  logic [OTYPE_W-1:0] gate_otype;

  cap_type_gate #(.ADDR_W(ADDR_W), .OTYPE_W(OTYPE_W)) u_gate (
    .do_unseal        (i_op == OP_UNSEAL),
    .src_tag          (src_tag),
    .src_otype        (src_otype),
    .auth_tag         (auth_tag),
    .auth_addr        (auth_addr),
    .auth_seal_perm   (auth_seal_perm),
    .auth_unseal_perm (auth_unseal_perm),
    .res_tag          (gate_tag),
    .res_otype        (gate_otype)
  );

  // Guarded edit path
  logic              edit_tag;
  logic [ADDR_W-1:0] edit_addr;
  logic [PERM_W-1:0] edit_perm;
  logic [ADDR_W-1:0] edit_base;
  logic [ADDR_W-1:0] edit_top;

  cap_field_edit #(.ADDR_W(ADDR_W), .PERM_W(PERM_W), .OTYPE_W(OTYPE_W)) u_edit (
    .src_tag   (src_tag),
    .src_addr  (src_addr),
    .src_perm  (src_perm),
    .src_base  (src_base),
    .src_top   (src_top),
    .src_otype (src_otype),
    .addr_en   (mod_addr_en),
    .new_addr  (mod_addr),
    .bnd_en    (mod_bnd_en),
    .new_base  (mod_base),
    .new_top   (mod_top),
    .perm_en   (mod_perm_en),
    .perm_mask (mod_perm_mask),
    .res_tag   (edit_tag),
    .res_addr  (edit_addr),
    .res_perm  (edit_perm),
    .res_base  (edit_base),
    .res_top   (edit_top)
  );

  // Next-state selection
  logic               nxt_tag;
  logic [ADDR_W-1:0]  nxt_addr;
  logic [PERM_W-1:0]  nxt_perm;
  logic [ADDR_W-1:0]  nxt_base;
  logic [ADDR_W-1:0]  nxt_top;
  logic [OTYPE_W-1:0] nxt_otype;
  logic               nxt_xs;

  always_comb begin
    nxt_tag   = src_tag;
    nxt_addr  = src_addr;
    nxt_perm  = src_perm;
    nxt_base  = src_base;
    nxt_top   = src_top;
    nxt_otype = src_otype;
    unique case (cap_op_e'(i_op))
      OP_MODIFY: begin
        nxt_tag  = edit_tag;
        nxt_addr = edit_addr;
        nxt_perm = edit_perm;
        nxt_base = edit_base;
        nxt_top  = edit_top;
      end
      OP_SEAL, OP_UNSEAL: begin
        nxt_tag   = gate_tag;
        nxt_otype = gate_otype;
      end
      OP_PASS: ;
      default: ;
    endcase
    nxt_xs = (nxt_otype != '0) && nxt_perm[EXEC_BIT];
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
    end else begin
      o_valid <= i_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_tag         <= 1'b0;
      o_addr        <= '0;
      o_perm        <= '0;
      o_base        <= '0;
      o_top         <= '0;
      o_otype       <= '0;
      o_exec_sealed <= 1'b0;
    end else if (i_valid) begin
      o_tag         <= nxt_tag;
      o_addr        <= nxt_addr;
      o_perm        <= nxt_perm;
      o_base        <= nxt_base;
      o_top         <= nxt_top;
      o_otype       <= nxt_otype;
      o_exec_sealed <= nxt_xs;
    end
  end
endmodule

// File: rtl/cap_seal_unit_chk.sv
module cap_seal_unit_chk
  import cap_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PERM_W  = 7,
  parameter int OTYPE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               i_valid,
  input logic [1:0]         i_op,
  input logic               src_tag,
  input logic [ADDR_W-1:0]  src_addr,
  input logic [OTYPE_W-1:0] src_otype,
  input logic               auth_tag,
  input logic               auth_seal_perm,
  input logic               mod_addr_en,
  input logic               mod_bnd_en,
  input logic               mod_perm_en,
  input logic               o_valid,
  input logic               o_tag,
  input logic [ADDR_W-1:0]  o_addr,
  input logic [PERM_W-1:0]  o_perm,
  input logic [OTYPE_W-1:0] o_otype,
  input logic               o_exec_sealed
);
  AST_SEAL_NEEDS_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == OP_SEAL && !(auth_tag && auth_seal_perm)) |=> !o_tag); // R3

  AST_SEALED_EDIT_UNTAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == OP_MODIFY && src_otype != '0 &&
     (mod_addr_en || mod_bnd_en || mod_perm_en)) |=> !o_tag); // R4

  AST_UNSEAL_CLEARS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == OP_UNSEAL) |=> (!o_tag || o_otype == '0)); // R5

  AST_PASS_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == OP_PASS) |=>
      (o_tag == $past(src_tag) && o_addr == $past(src_addr) &&
       o_otype == $past(src_otype))); // R7

  AST_EXEC_SEALED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    o_exec_sealed |-> (o_otype != '0 && o_perm[PERM_EXEC])); // R8

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |=> o_valid); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> (!o_valid && $stable(o_addr) && $stable(o_tag))); // R9
endmodule

bind cap_seal_unit cap_seal_unit_chk #(
  .ADDR_W(ADDR_W), .PERM_W(PERM_W), .OTYPE_W(OTYPE_W)
) u_chk (.*);

// File: tb/tb_cap_seal_unit.sv
module tb_cap_seal_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int PW = 7;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic i_valid;
  logic [1:0] i_op;
  logic src_tag;
  logic [AW-1:0] src_addr, src_base, src_top;
  logic [PW-1:0] src_perm;
  logic [TW-1:0] src_otype;
  logic auth_tag, auth_seal_perm, auth_unseal_perm;
  logic [AW-1:0] auth_addr;
  logic mod_addr_en, mod_bnd_en, mod_perm_en;
  logic [AW-1:0] mod_addr, mod_base, mod_top;
  logic [PW-1:0] mod_perm_mask;
  logic o_valid, o_tag, o_exec_sealed;
  logic [AW-1:0] o_addr, o_base, o_top;
  logic [PW-1:0] o_perm;
  logic [TW-1:0] o_otype;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic          tag;
    logic [AW-1:0] addr;
    logic [PW-1:0] perm;
    logic [AW-1:0] base;
    logic [AW-1:0] top;
    logic [TW-1:0] ot;
    logic          xs;
  } res_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_seal_unit dut (.*);

  // Behavioural reference of one request
  function automatic res_t model();
    res_t r;
    int a;
    bit grant;
    r.tag = src_tag; r.addr = src_addr; r.perm = src_perm;
    r.base = src_base; r.top = src_top; r.ot = src_otype;
    a = int'(auth_addr);
    case (i_op)
      2'b00: begin
        if (mod_addr_en) r.addr = mod_addr;
        if (mod_bnd_en) begin r.base = mod_base; r.top = mod_top; end
        if (mod_perm_en) r.perm = src_perm & mod_perm_mask;
        if (src_otype != 0 && (mod_addr_en || mod_bnd_en || mod_perm_en)) r.tag = 1'b0;
      end
      2'b01: begin
        grant = auth_tag && auth_seal_perm && src_otype == 0 && auth_addr >= 1 && auth_addr <= 7;
        if (grant) r.ot = auth_addr[2:0];
        r.tag = src_tag && grant;
      end
      2'b10: begin
        grant = auth_tag && auth_unseal_perm && src_otype != 0 && auth_addr == {29'd0, src_otype};
        if (grant) r.ot = 3'd0;
        r.tag = src_tag && grant;
      end
      default: ;
    endcase
    r.xs = (r.ot != 0) && r.perm[3];
    return r;
  endfunction

  function automatic res_t actual();
    return {o_tag, o_addr, o_perm, o_base, o_top, o_otype, o_exec_sealed};
  endfunction

  task automatic compare(input string req, input res_t exp, input logic exp_valid);
    res_t act;
    act = actual();
    checks++;
    if (act !== exp || o_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s: actual valid=%b res=%h expected valid=%b res=%h",
               req, o_valid, act, exp_valid, exp);
    end
  endtask

  task automatic set_src(input logic t, input logic [AW-1:0] a,
                         input logic [PW-1:0] p, input logic [TW-1:0] ot);
    src_tag = t; src_addr = a; src_perm = p; src_otype = ot;
    src_base = a - 32'h10; src_top = a + 32'h40;
    mod_addr_en = 0; mod_bnd_en = 0; mod_perm_en = 0;
  endtask

  task automatic set_auth(input logic t, input logic [AW-1:0] a,
                          input logic s, input logic u);
    auth_tag = t; auth_addr = a; auth_seal_perm = s; auth_unseal_perm = u;
  endtask

  // Called at a falling edge; result is checked at the next falling edge.
  task automatic issue(input logic [1:0] op, input string req);
    res_t exp;
    i_op = op; i_valid = 1'b1;
    exp = model();
    @(negedge clk);
    compare(req, exp, 1'b1);
    i_valid = 1'b0;
  endtask

  task automatic idle_cycle(input string req);
    res_t hold;
    hold = actual();
    src_addr = $urandom; src_tag = ~src_tag; i_op = $urandom;
    @(negedge clk);
    compare(req, hold, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual run still going expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; i_valid = 1'b0; i_op = 2'b11;
    set_src(1, 32'h100, 7'h0F, 0);
    set_auth(0, 0, 0, 0);
    mod_addr = 0; mod_base = 0; mod_top = 0; mod_perm_mask = 0;
    repeat (3) @(negedge clk);
    compare("R1", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", '0, 1'b0);

    // Sealing
    set_src(1, 32'h1000, 7'h0F, 0); set_auth(1, 5, 1, 0);
    issue(2'b01, "R2");
    set_src(1, 32'h1000, 7'h07, 0); set_auth(1, 7, 1, 0);
    issue(2'b01, "R2");
    set_src(1, 32'h1000, 7'h0F, 0); set_auth(1, 5, 0, 1);
    issue(2'b01, "R3");
    set_auth(0, 5, 1, 0);
    issue(2'b01, "R3");
    set_auth(1, 0, 1, 0);
    issue(2'b01, "R3");
    set_auth(1, 8, 1, 0);
    issue(2'b01, "R3");
    set_src(1, 32'h1000, 7'h0F, 2); set_auth(1, 5, 1, 0);
    issue(2'b01, "R3");

    // Unsealing
    set_src(1, 32'h2000, 7'h0B, 6); set_auth(1, 6, 0, 1);
    issue(2'b10, "R5");
    set_auth(1, 7, 0, 1);
    issue(2'b10, "R6");
    set_auth(1, 32'h106, 0, 1);
    issue(2'b10, "R6");
    set_auth(1, 6, 1, 0);
    issue(2'b10, "R6");
    set_auth(0, 6, 0, 1);
    issue(2'b10, "R6");
    set_src(1, 32'h2000, 7'h0B, 0); set_auth(1, 0, 0, 1);
    issue(2'b10, "R6");

    // Editing and copying
    set_src(1, 32'h3000, 7'h7F, 0); mod_addr_en = 1; mod_addr = 32'h3004;
    issue(2'b00, "R4");
    set_src(1, 32'h3000, 7'h7F, 0); mod_perm_en = 1; mod_perm_mask = 7'h1B;
    issue(2'b00, "R4");
    set_src(1, 32'h3000, 7'h7F, 4); mod_bnd_en = 1; mod_base = 32'h2F00; mod_top = 32'h3100;
    issue(2'b00, "R4");
    set_src(1, 32'h3000, 7'h7F, 4); mod_perm_en = 1; mod_perm_mask = 7'h7F;
    issue(2'b00, "R4");
    set_src(1, 32'h3000, 7'h7F, 4);
    issue(2'b00, "R7");
    set_src(1, 32'h3000, 7'h08, 3);
    issue(2'b11, "R7");
    set_src(1, 32'h3000, 7'h08, 3);
    issue(2'b11, "R8");
    set_src(1, 32'h3000, 7'h07, 3);
    issue(2'b11, "R8");
    idle_cycle("R9");
    idle_cycle("R9");

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      set_src($urandom_range(0, 3) != 0, $urandom, $urandom, $urandom_range(0, 7));
      set_auth($urandom_range(0, 4) != 0,
               ($urandom_range(0, 2) == 0) ? {29'd0, src_otype} : $urandom_range(0, 9),
               $urandom, $urandom);
      mod_addr_en = $urandom; mod_bnd_en = $urandom; mod_perm_en = $urandom;
      mod_addr = $urandom; mod_base = $urandom; mod_top = $urandom; mod_perm_mask = $urandom;
      issue($urandom, "R9");
      if ($urandom_range(0, 4) == 0) idle_cycle("R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule